// File: doc/BRIEF.md
# Masked Block-Write Fill Engine

This block implements the block-write fill used by a graphics frame-buffer memory. A stored color word is copied into a group of eight neighbouring 32-bit column locations by one command. Each column of the group is written only when its own enable bit is set, and any of the four bytes in a word can be held back by a byte-mask bit. Both banks take their fill value from the same color register.

The color register is loaded through a plain load strobe. A block-write command arrives on a valid/ready channel that carries the bank, a column address, eight column-enable bits and four byte-mask bits. The channel only back-pressures while reset is held. Outside reset `bw_ready` is high, so a command is taken on every clock edge where `bw_valid` is high. Each accepted command updates the word array at that edge. A combinational read port on the array lets the surrounding logic read back any word.

Top module: `bwfill_top`

## Requirements
- R1: While `rst_n` is low, every word of both banks is cleared to zero and the color register is cleared to zero.
- R2: A `color_ld` pulse captures `color_data` at that clock edge. A block write accepted on the next edge fills with the new value.
- R3: If a block write is accepted on the same edge as a color load, it fills with the color held before that load.
- R4: The group base is `bw_col` with its three low bits forced to zero. Bit i of `bw_colen` controls the column at base + i, for i = 0 to 7.
- R5: A column whose `bw_colen` bit is 0 keeps its previous contents.
- R6: Bit j of `bw_bytemask` set to 1 keeps bits [8j+7:8j] of every enabled column unchanged. A mask bit of 0 lets that byte take the color.
- R7: Only the bank selected by `bw_bank` (0 or 1) is changed. The one color register serves both banks.
- R8: An accepted write appears on `rd_data` immediately after the edge that accepts it. Before that edge, `rd_data` still shows the old value.
- R9: `bw_ready` is low while `rst_n` is low and high otherwise. A cycle with `bw_valid` low changes no word.
- R10: Columns outside the addressed eight-column group are never changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| color_ld | input | 1 | Load strobe for the color register |
| color_data | input | 32 | Value captured on load |
| bw_valid | input | 1 | Block-write command present |
| bw_ready | output | 1 | Command can be accepted |
| bw_bank | input | 1 | Target bank |
| bw_col | input | 6 | Column address; low three bits ignored |
| bw_colen | input | 8 | Per-column write enables, bit i gives column base+i |
| bw_bytemask | input | 4 | Byte suppress bits, bit j covers byte j |
| rd_bank | input | 1 | Read bank |
| rd_col | input | 6 | Read column |
| rd_data | output | 32 | Word at the read location |

## Verification
The bench sends unaligned column addresses. A design that used the full address would shift the group, so words outside the group would change (R10) and words inside it would be missed. Some commands enable no columns, and some mask all four bytes. A wrong gate on either path would overwrite words that must stay the same. The bench also loads the color register on the same edge as a write. A design that forwarded the new color, or that stored it late, would put the wrong value in the group.

// File: rtl/bwfill_pkg.sv
package bwfill_pkg;
  localparam int WORD_W   = 32;
  localparam int BYTE_W   = 8;
  localparam int BLK_COLS = 8;
  localparam int BYTES    = WORD_W / BYTE_W;
endpackage

// File: rtl/bwfill_color.sv
module bwfill_color #(
  parameter int WORD_W = bwfill_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] color_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  color_q <= '0;
    else if (ld) color_q <= din;
  end
endmodule

// File: rtl/bwfill_decode.sv
module bwfill_decode #(
  parameter int COL_AW   = 6,
  parameter int BLK_COLS = bwfill_pkg::BLK_COLS,
  parameter int BYTES    = bwfill_pkg::BYTES,
  localparam int BLK_LOG = $clog2(BLK_COLS),
  localparam int GRP_W   = COL_AW - BLK_LOG
) (
  input  logic                accept,
  input  logic [COL_AW-1:0]   col,
  input  logic [BLK_COLS-1:0] colen,
  input  logic [BYTES-1:0]    bytemask,
  output logic [GRP_W-1:0]    grp,
  output logic [BLK_COLS-1:0] col_we,
  output logic [BYTES-1:0]    byte_we
);
  // group index drops the in-group column bits
  assign grp = col[COL_AW-1:BLK_LOG];

  always_comb begin
    col_we  = accept ? colen : '0;
    byte_we = ~bytemask;
  end
endmodule

// File: rtl/bwfill_array.sv
module bwfill_array #(
  parameter int NUM_BANKS = 2,
  parameter int COLS      = 64,
  parameter int WORD_W    = bwfill_pkg::WORD_W,
  parameter int BYTE_W    = bwfill_pkg::BYTE_W,
  parameter int BLK_COLS  = bwfill_pkg::BLK_COLS,
  localparam int BYTES    = WORD_W / BYTE_W,
  localparam int COL_AW   = $clog2(COLS),
  localparam int BANK_AW  = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int BLK_LOG  = $clog2(BLK_COLS),
  localparam int GRP_W    = COL_AW - BLK_LOG
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [BANK_AW-1:0]  wr_bank,
  input  logic [GRP_W-1:0]    wr_grp,
  input  logic [BLK_COLS-1:0] col_we,
  input  logic [BYTES-1:0]    byte_we,
  input  logic [WORD_W-1:0]   wr_word,
  input  logic [BANK_AW-1:0]  rd_bank,
  input  logic [COL_AW-1:0]   rd_col,
  output logic [WORD_W-1:0]   rd_data
);
  logic [WORD_W-1:0] bank_rd [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [WORD_W-1:0] mem [COLS];
    logic              sel;
    assign sel = (wr_bank == BANK_AW'(b));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int k = 0; k < COLS; k++) mem[k] <= '0;
      end else if (sel) begin
        for (int i = 0; i < BLK_COLS; i++) begin
          for (int j = 0; j < BYTES; j++) begin
            if (col_we[i] && byte_we[j])
              mem[{wr_grp, BLK_LOG'(i)}][j*BYTE_W +: BYTE_W] <= wr_word[j*BYTE_W +: BYTE_W];
          end
        end
      end
    end

    assign bank_rd[b] = mem[rd_col];
  end

  assign rd_data = bank_rd[rd_bank];
endmodule

// File: rtl/bwfill_top.sv
module bwfill_top #(
  parameter int NUM_BANKS = 2,
  parameter int COLS      = 64,
  parameter int WORD_W    = bwfill_pkg::WORD_W,
  parameter int BLK_COLS  = bwfill_pkg::BLK_COLS,
  localparam int BYTES    = WORD_W / bwfill_pkg::BYTE_W,
  localparam int COL_AW   = $clog2(COLS),
  localparam int BANK_AW  = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int GRP_W    = COL_AW - $clog2(BLK_COLS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                color_ld,
  input  logic [WORD_W-1:0]   color_data,
  input  logic                bw_valid,
  output logic                bw_ready,
  input  logic [BANK_AW-1:0]  bw_bank,
  input  logic [COL_AW-1:0]   bw_col,
  input  logic [BLK_COLS-1:0] bw_colen,
  input  logic [BYTES-1:0]    bw_bytemask,
  input  logic [BANK_AW-1:0]  rd_bank,
  input  logic [COL_AW-1:0]   rd_col,
  output logic [WORD_W-1:0]   rd_data
);
  logic [WORD_W-1:0]   color_q;
  logic [GRP_W-1:0]    grp;
  logic [BLK_COLS-1:0] col_we;
  logic [BYTES-1:0]    byte_we;
  logic                accept;

  assign bw_ready = rst_n;
  assign accept   = bw_valid & bw_ready;

  bwfill_color #(.WORD_W(WORD_W)) u_color (
    .clk(clk), .rst_n(rst_n), .ld(color_ld), .din(color_data), .color_q(color_q)
  );

  bwfill_decode #(.COL_AW(COL_AW), .BLK_COLS(BLK_COLS), .BYTES(BYTES)) u_dec (
    .accept(accept), .col(bw_col), .colen(bw_colen), .bytemask(bw_bytemask),
    .grp(grp), .col_we(col_we), .byte_we(byte_we)
  );

  bwfill_array #(.NUM_BANKS(NUM_BANKS), .COLS(COLS), .WORD_W(WORD_W),
                 .BLK_COLS(BLK_COLS)) u_arr (
    .clk(clk), .rst_n(rst_n), .wr_bank(bw_bank), .wr_grp(grp), .col_we(col_we),
    .byte_we(byte_we), .wr_word(color_q), .rd_bank(rd_bank), .rd_col(rd_col),
    .rd_data(rd_data)
  );
endmodule

// File: rtl/bwfill_chk.sv
module bwfill_chk #(
  parameter int WORD_W   = bwfill_pkg::WORD_W,
  parameter int BLK_COLS = bwfill_pkg::BLK_COLS,
  parameter int BYTES    = bwfill_pkg::BYTES
) (
  input logic                clk,
  input logic                rst_n,
  input logic                color_ld,
  input logic [WORD_W-1:0]   color_data,
  input logic [WORD_W-1:0]   color_q,
  input logic                bw_valid,
  input logic [BLK_COLS-1:0] bw_colen,
  input logic [BYTES-1:0]    bw_bytemask,
  input logic [BLK_COLS-1:0] col_we,
  input logic [BYTES-1:0]    byte_we
);
  // R2
  color_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    color_ld |=> color_q == $past(color_data));
  // R3
  color_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !color_ld |=> $stable(color_q));
  // R5
  colen_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (col_we & ~bw_colen) == '0);
  // R6
  byte_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|col_we) |-> byte_we == ~bw_bytemask);
  // R9
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bw_valid |-> col_we == '0);
endmodule

bind bwfill_top bwfill_chk #(.WORD_W(WORD_W), .BLK_COLS(BLK_COLS), .BYTES(BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .color_ld(color_ld), .color_data(color_data),
  .color_q(color_q), .bw_valid(bw_valid), .bw_colen(bw_colen),
  .bw_bytemask(bw_bytemask), .col_we(col_we), .byte_we(byte_we)
);

// File: tb/bwfill_top_bench.sv
`timescale 1ns/1ps
module bwfill_top_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        color_ld = 0;
  logic [31:0] color_data = '0;
  logic        bw_valid = 0;
  logic        bw_ready;
  logic        bw_bank = 0;
  logic [5:0]  bw_col = '0;
  logic [7:0]  bw_colen = '0;
  logic [3:0]  bw_bytemask = '0;
  logic        rd_bank = 0;
  logic [5:0]  rd_col = '0;
  logic [31:0] rd_data;

  int checks = 0;
  int fails  = 0;
  logic [31:0] model [2][64];

  always #2 clk = ~clk;

  bwfill_top u_bwfill_top (.*);

  // vector: bank(1) col(6) colen(8) mask(4) color(32)
  localparam int NV = 8;
  localparam logic [50:0] VEC [NV] = '{
    {1'b0, 6'd0,  8'hFF, 4'h0, 32'h11223344},
    {1'b1, 6'd13, 8'hA5, 4'h0, 32'hCAFEF00D},
    {1'b0, 6'd63, 8'hFF, 4'h5, 32'hDEADBEEF},
    {1'b1, 6'd8,  8'h3C, 4'hA, 32'h01020304},
    {1'b0, 6'd7,  8'h00, 4'h0, 32'hFFFFFFFF},
    {1'b0, 6'd2,  8'h81, 4'hF, 32'h55555555},
    {1'b1, 6'd40, 8'hFF, 4'h0, 32'h89ABCDEF},
    {1'b0, 6'd57, 8'h0F, 4'h8, 32'h76543210}
  };

  task automatic model_write(input logic b, input logic [5:0] c, input logic [7:0] en,
                             input logic [3:0] m, input logic [31:0] v);
    for (int i = 0; i < 8; i++) begin
      if (en[i]) begin
        for (int j = 0; j < 4; j++)
          if (!m[j]) model[b][{c[5:3], 3'(i)}][j*8 +: 8] = v[j*8 +: 8];
      end
    end
  endtask

  task automatic check_all(input string tag);
    int bad = 0;
    for (int b = 0; b < 2; b++) begin
      for (int c = 0; c < 64; c++) begin
        rd_bank = b[0]; rd_col = c[5:0];
        #0.01;
        if (rd_data !== model[b][c]) begin
          if (bad == 0)
            $display("FAIL %s bank %0d col %0d actual %h expected %h",
                     tag, b, c, rd_data, model[b][c]);
          bad++;
        end
      end
    end
    checks++;
    if (bad != 0) fails++;
  endtask

  task automatic check_val(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int b = 0; b < 2; b++)
      for (int c = 0; c < 64; c++) model[b][c] = '0;
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    clear_model();
    repeat (3) @(negedge clk);
    check_val("R9 ready low in reset", {31'b0, bw_ready}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    check_val("R9 ready high after reset", {31'b0, bw_ready}, 32'd1);
    check_all("R1 reset clears array");

    // R1: color cleared -> a write of all columns puts zero
    bw_bank = 0; bw_col = 6'd16; bw_colen = 8'hFF; bw_bytemask = 4'h0; bw_valid = 1;
    @(negedge clk); bw_valid = 0;
    check_all("R1 color reset value zero");

    // table: R2 R4 R5 R6 R7 R10
    for (int k = 0; k < NV; k++) begin
      color_ld = 1; color_data = VEC[k][31:0];
      @(negedge clk);
      color_ld = 0;
      bw_valid = 1; bw_bank = VEC[k][50]; bw_col = VEC[k][49:44];
      bw_colen = VEC[k][43:36]; bw_bytemask = VEC[k][35:32];
      @(negedge clk);
      bw_valid = 0;
      model_write(VEC[k][50], VEC[k][49:44], VEC[k][43:36], VEC[k][35:32], VEC[k][31:0]);
      check_all($sformatf("R2/R4/R5/R6/R7/R10 vector %0d", k));
    end

    // R3: load and write on the same edge use the old color
    color_ld = 1; color_data = 32'hA1A2A3A4;
    @(negedge clk);
    color_ld = 1; color_data = 32'hB1B2B3B4;
    bw_valid = 1; bw_bank = 1; bw_col = 6'd50; bw_colen = 8'h01; bw_bytemask = 4'h0;
    @(negedge clk);
    color_ld = 0; bw_col = 6'd51; bw_colen = 8'h02;
    model_write(1, 6'd50, 8'h01, 4'h0, 32'hA1A2A3A4);
    @(negedge clk);
    bw_valid = 0;
    model_write(1, 6'd51, 8'h02, 4'h0, 32'hB1B2B3B4);
    check_all("R3 same-edge load keeps old color");

    // R8: old value before the edge, new value just after it
    color_ld = 1; color_data = 32'h0F0F0F0F;
    @(negedge clk);
    color_ld = 0; bw_valid = 1; bw_bank = 0; bw_col = 6'd33; bw_colen = 8'h02; bw_bytemask = 4'h0;
    rd_bank = 0; rd_col = 6'd33;
    #1;
    check_val("R8 before accepting edge", rd_data, model[0][33]);
    @(posedge clk); #0.5;
    check_val("R8 right after accepting edge", rd_data, 32'h0F0F0F0F);
    @(negedge clk);
    bw_valid = 0;
    model_write(0, 6'd33, 8'h02, 4'h0, 32'h0F0F0F0F);

    // R9: command fields with valid low change nothing
    bw_valid = 0; bw_bank = 0; bw_col = 6'd0; bw_colen = 8'hFF; bw_bytemask = 4'h0;
    repeat (3) @(negedge clk);
    check_all("R9 valid low no effect");

    // R1/R9: reset mid-run clears array, blocks commands
    rst_n = 0; bw_valid = 1;
    @(negedge clk);
    check_val("R9 ready low in second reset", {31'b0, bw_ready}, 32'd0);
    @(negedge clk);
    bw_valid = 0; rst_n = 1;
    clear_model();
    @(negedge clk);
    check_all("R1 second reset clears array");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule